// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block arbitrates up to sixteen interrupt sources for a small microcontroller core and sequences entry into the selected handler. Each source is built as one of two kinds, chosen by a parameter mask. An event source latches a flag on a rising edge of its input. A level source has no flag and requests only while its input is high. A request is eligible when its own enable and the global enable are both set. Among the eligible requests, the lowest source index wins.

The core is modelled only by handshakes. `retire_i` marks an instruction boundary, and `sei_i`, `cli_i` and `reti_i` qualify the retiring instruction. `sleep_i` means the core is idle and asleep. When an interrupt is taken, the controller does four things: it clears the global enable, clears the served flag, holds `entering_o` high for the return-address save window, and then presents a vector address. That address stays valid until the core raises `entry_ack_i`. Vector index 0 is reserved for reset, so source `i` uses vector index `i+1`.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, `gie_o`, `flag_o`, `entering_o` and `vec_valid_o` are all 0.
- R2: A source is taken only when its `en_i` bit and the global enable are both 1. With either one clear, retirements cause no entry.
- R3: When several requests are eligible, the lowest source index is served first. Source `i` maps to vector index `i+1`.
- R4: `vec_addr_o` equals `BASE_A + (i+1)*ENTRY_SZ`, or `BASE_B + (i+1)*ENTRY_SZ` when `alt_base_i` is 1 at the take boundary (defaults: BASE_A 0x0000, BASE_B 0x1C00, ENTRY_SZ 2).
- R5: An event source sets its `flag_o` bit on a rising edge of `src_i`. The flag stays set while the source is disabled or the global enable is 0. A rising edge in the same cycle as a clear strobe leaves the flag set.
- R6: A 1 on a `flag_clr_i` bit clears that flag and leaves the other flags unchanged.
- R7: Entry clears the global enable and the served flag, visible in the first entry cycle. A retirement with `reti_i` sets the global enable, and so does one with `sei_i`.
- R8: Level sources (default: sources 12 to 15) never show a flag. They request only while `src_i` is high, so a pulse that ends before the source is enabled is lost.
- R9: The retirement of an SEI or RETI never starts an entry. The next ordinary retirement may start one.
- R10: A retirement with `cli_i` clears the global enable and starts no entry, even with a request present in that cycle.
- R11: Outside sleep, an entry starts only on a cycle with `retire_i` high, so an instruction that spans several cycles completes first.
- R12: `entering_o` stays high for ENTRY_CYC cycles (4), or ENTRY_CYC+SLEEP_CYC cycles (8) when the entry starts from sleep. After that, `vec_valid_o` stays high with a stable address until `entry_ack_i`.
- R13: Several pending flags are served one per entry, in priority order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | N_SRC | Raw interrupt conditions |
| en_i | input | N_SRC | Per-source enables |
| flag_clr_i | input | N_SRC | Write-one-to-clear strobes for event flags |
| retire_i | input | 1 | An instruction retires this cycle |
| sei_i | input | 1 | The retiring instruction sets the global enable |
| cli_i | input | 1 | The retiring instruction clears the global enable |
| reti_i | input | 1 | The retiring instruction is a return from interrupt |
| sleep_i | input | 1 | Core is asleep |
| alt_base_i | input | 1 | Selects the alternate vector base |
| entry_ack_i | input | 1 | Core accepts the presented vector |
| gie_o | output | 1 | Global enable state |
| flag_o | output | N_SRC | Latched event flags |
| entering_o | output | 1 | Return-address save window in progress |
| vec_valid_o | output | 1 | Vector address is valid |
| vec_addr_o | output | ADDR_W | Vector address |

## Verification
A rising edge on `src_i` shows in `flag_o` one cycle later. A retirement moves `gie_o` and `entering_o` one cycle later, and the bench reads both at the falling edge after that clock. The vector is due ENTRY_CYC cycles after `entering_o` first reads high, or ENTRY_CYC+SLEEP_CYC cycles from sleep. The bench counts those cycles and then checks that the address holds through extra cycles until the acknowledge. The no-entry checks read `entering_o` and `gie_o` one cycle after the SEI, RETI, CLI or non-retiring cycle in question, before any further stimulus.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ENTRY, ST_VEC} seq_st_e;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int              N_SRC    = 16,
  parameter logic [N_SRC-1:0] LVL_MASK = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic [N_SRC-1:0] served_i,
  output logic [N_SRC-1:0] flag_o,
  output logic [N_SRC-1:0] req_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (LVL_MASK[i]) begin : g_lvl
      logic unused_bits;
      assign unused_bits = ^{clr_i[i], served_i[i]};
      assign flag_o[i]   = 1'b0;
      assign req_o[i]    = src_i[i] & en_i[i];
    end else begin : g_evt
      logic src_q, flag_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          src_q  <= 1'b0;
          flag_q <= 1'b0;
        end else begin
          src_q <= src_i[i];
          if (src_i[i] && !src_q)            flag_q <= 1'b1; // new event wins over clear
          else if (clr_i[i] || served_i[i])  flag_q <= 1'b0;
        end
      end
      assign flag_o[i] = flag_q;
      assign req_o[i]  = flag_q & en_i[i];

      a_r5_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_q && !clr_i[i] && !served_i[i]) |=> flag_q);
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_SRC = 16,
  parameter int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N_SRC-1:0] grant_o
);
  assign any_o = |req_i;

  always_comb begin
    idx_o   = '0;
    grant_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o      = IDX_W'(i);
        grant_o    = '0;
        grant_o[i] = 1'b1;
      end
    end
    if (any_o) begin
      a_r3_lowest_wins: assert ((req_i & (grant_o - 1'b1)) == '0 && (grant_o & req_i) != '0);
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_pkg::*;
#(
  parameter int             N_SRC     = 16,
  parameter int             IDX_W     = $clog2(N_SRC),
  parameter int             ADDR_W    = 16,
  parameter int             ENTRY_CYC = 4,
  parameter int             SLEEP_CYC = 4,
  parameter int             ENTRY_SZ  = 2,
  parameter logic [ADDR_W-1:0] BASE_A = '0,
  parameter logic [ADDR_W-1:0] BASE_B = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              any_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [N_SRC-1:0]  grant_i,
  input  logic              retire_i,
  input  logic              sei_i,
  input  logic              cli_i,
  input  logic              reti_i,
  input  logic              sleep_i,
  input  logic              alt_base_i,
  input  logic              entry_ack_i,
  output logic [N_SRC-1:0]  served_o,
  output logic              gie_o,
  output logic              entering_o,
  output logic              vec_valid_o,
  output logic [ADDR_W-1:0] vec_addr_o
);
  localparam int CNT_W = $clog2(ENTRY_CYC + SLEEP_CYC + 1);

  seq_st_e            st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               gie_q;
  logic [ADDR_W-1:0]  vec_q;
  logic               boundary, gate_ok, take;
  logic [ADDR_W-1:0]  base_sel, vec_d;

  assign boundary = retire_i | sleep_i;
  assign gate_ok  = !(retire_i && (sei_i || cli_i || reti_i)); // shadow of SEI/RETI, CLI immediate
  assign take     = (st_q == ST_IDLE) && gie_q && any_i && boundary && gate_ok;
  assign served_o = take ? grant_i : '0;
  assign base_sel = alt_base_i ? BASE_B : BASE_A;
  assign vec_d    = base_sel + ADDR_W'((int'(idx_i) + 1) * ENTRY_SZ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      gie_q <= 1'b0;
      vec_q <= '0;
    end else begin
      if (take)                              gie_q <= 1'b0;
      else if (retire_i && cli_i)            gie_q <= 1'b0;
      else if (retire_i && (sei_i || reti_i)) gie_q <= 1'b1;

      unique case (st_q)
        ST_IDLE: if (take) begin
          st_q  <= ST_ENTRY;
          vec_q <= vec_d;
          cnt_q <= sleep_i ? CNT_W'(ENTRY_CYC + SLEEP_CYC - 1) : CNT_W'(ENTRY_CYC - 1);
        end
        ST_ENTRY: begin
          if (cnt_q == '0) st_q <= ST_VEC;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_VEC: if (entry_ack_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign gie_o       = gie_q;
  assign entering_o  = (st_q == ST_ENTRY);
  assign vec_valid_o = (st_q == ST_VEC);
  assign vec_addr_o  = vec_q;

  a_r7_gie_clr_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(entering_o) |-> !gie_o);
  a_r9_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && retire_i && (sei_i || reti_i) && !cli_i) |=> (st_q == ST_IDLE && gie_q));
  a_r10_cli_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && retire_i && cli_i) |=> (st_q == ST_IDLE && !gie_q));
  a_r11_boundary_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !retire_i && !sleep_i) |=> st_q == ST_IDLE);
  a_r12_vec_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_VEC && !entry_ack_i) |=> (st_q == ST_VEC && $stable(vec_q)));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int                N_SRC     = 16,
  parameter int                ADDR_W    = 16,
  parameter int                ENTRY_CYC = 4,
  parameter int                SLEEP_CYC = 4,
  parameter int                ENTRY_SZ  = 2,
  parameter logic [ADDR_W-1:0] BASE_A    = 16'h0000,
  parameter logic [ADDR_W-1:0] BASE_B    = 16'h1C00,
  parameter logic [N_SRC-1:0]  LVL_MASK  = 16'hF000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [N_SRC-1:0]  en_i,
  input  logic [N_SRC-1:0]  flag_clr_i,
  input  logic              retire_i,
  input  logic              sei_i,
  input  logic              cli_i,
  input  logic              reti_i,
  input  logic              sleep_i,
  input  logic              alt_base_i,
  input  logic              entry_ack_i,
  output logic              gie_o,
  output logic [N_SRC-1:0]  flag_o,
  output logic              entering_o,
  output logic              vec_valid_o,
  output logic [ADDR_W-1:0] vec_addr_o
);
  localparam int IDX_W = $clog2(N_SRC);

  logic [N_SRC-1:0] req, grant, served;
  logic             any;
  logic [IDX_W-1:0] idx;

  irq_src_bank #(.N_SRC(N_SRC), .LVL_MASK(LVL_MASK)) u_bank (
    .clk_i, .rst_ni, .src_i, .en_i, .clr_i(flag_clr_i), .served_i(served),
    .flag_o, .req_o(req)
  );

  irq_prio_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
    .req_i(req), .any_o(any), .idx_o(idx), .grant_o(grant)
  );

  irq_seq #(
    .N_SRC(N_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .ENTRY_CYC(ENTRY_CYC),
    .SLEEP_CYC(SLEEP_CYC), .ENTRY_SZ(ENTRY_SZ), .BASE_A(BASE_A), .BASE_B(BASE_B)
  ) u_seq (
    .clk_i, .rst_ni, .any_i(any), .idx_i(idx), .grant_i(grant),
    .retire_i, .sei_i, .cli_i, .reti_i, .sleep_i, .alt_base_i, .entry_ack_i,
    .served_o(served), .gie_o, .entering_o, .vec_valid_o, .vec_addr_o
  );
endmodule

// File: tb/irq_vec_ctrl_tb_top.sv
module irq_vec_ctrl_tb_top;
  localparam int N = 16;
  localparam int BASE_A = 'h0000;
  localparam int BASE_B = 'h1C00;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] src_i = '0, en_i = '0, flag_clr_i = '0;
  logic retire_i = 0, sei_i = 0, cli_i = 0, reti_i = 0, sleep_i = 0, alt_base_i = 0, entry_ack_i = 0;
  logic gie_o, entering_o, vec_valid_o;
  logic [N-1:0] flag_o;
  logic [15:0] vec_addr_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  irq_vec_ctrl dut_i (
    .clk_i, .rst_ni, .src_i, .en_i, .flag_clr_i, .retire_i, .sei_i, .cli_i, .reti_i,
    .sleep_i, .alt_base_i, .entry_ack_i, .gie_o, .flag_o, .entering_o, .vec_valid_o, .vec_addr_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic instr(logic s, logic c, logic r);
    retire_i = 1; sei_i = s; cli_i = c; reti_i = r;
    tick();
    retire_i = 0; sei_i = 0; cli_i = 0; reti_i = 0;
  endtask

  task automatic pulse_src(int i);
    src_i[i] = 1; tick(); src_i[i] = 0; tick();
  endtask

  task automatic finish_entry(int idx, int len, int base);
    int n = 0;
    while (entering_o && n < 20) begin n++; tick(); end
    chk("R12 entry length", n, len);
    chk("R12 vector valid", vec_valid_o, 1);
    chk("R4 vector address", vec_addr_o, base + (idx + 1) * 2);
    repeat (2) tick();
    chk("R12 vector held", {vec_valid_o, vec_addr_o}, {1'b1, 16'(base + (idx + 1) * 2)});
    entry_ack_i = 1; tick(); entry_ack_i = 0;
    chk("R12 released by ack", vec_valid_o, 0);
  endtask

  task automatic take_now(int idx, int base);
    instr(0, 0, 0);
    chk("R3 entry started", entering_o, 1);
    chk("R7 gie cleared on entry", gie_o, 0);
    finish_entry(idx, 4, base);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk("R1 gie reset", gie_o, 0);
    chk("R1 flags reset", flag_o, 0);
    chk("R1 entering reset", entering_o, 0);
    chk("R1 vec_valid reset", vec_valid_o, 0);
    rst_ni = 1;
    tick();
    chk("R1 idle after release", {gie_o, entering_o, vec_valid_o, flag_o}, 0);

    // R3 R4 R5 R7 R9: each event source alone, both bases
    for (int i = 0; i < 12; i++) begin
      en_i = N'(1) << i;
      alt_base_i = i[0];
      pulse_src(i);
      chk("R5 flag set by edge", flag_o[i], 1);
      chk("R11 no entry without retire", entering_o, 0);
      instr(1, 0, 0);
      chk("R7 sei sets gie", gie_o, 1);
      chk("R9 no entry on sei boundary", entering_o, 0);
      instr(0, 0, 0);
      chk("R3 entry started", entering_o, 1);
      chk("R7 gie cleared", gie_o, 0);
      chk("R7 served flag cleared", flag_o[i], 0);
      finish_entry(i, 4, i[0] ? BASE_B : BASE_A);
      instr(0, 0, 1);
      chk("R7 reti sets gie", gie_o, 1);
    end
    alt_base_i = 0;

    // R8: level sources, no flag, serve while held
    for (int i = 12; i < 16; i++) begin
      en_i = N'(1) << i;
      src_i[i] = 1; tick();
      chk("R8 level has no flag", flag_o[i], 0);
      take_now(i, BASE_A);
      src_i[i] = 0;
      instr(0, 0, 1);
    end
    en_i = '0;
    src_i[12] = 1; tick(); src_i[12] = 0; tick();
    en_i = N'(1) << 12;
    instr(0, 0, 0);
    chk("R8 vanished level request lost", entering_o, 0);

    // R3 R9 R13: pairwise priority among event sources
    en_i = '1;
    for (int i = 0; i < 12; i++) begin
      for (int j = i + 1; j < 12; j++) begin
        src_i[i] = 1; src_i[j] = 1; tick(); src_i = '0; tick();
        take_now(i, BASE_A);
        chk("R5 loser flag kept", flag_o[j], 1);
        instr(0, 0, 1);
        chk("R9 no entry on reti boundary", entering_o, 0);
        take_now(j, BASE_A);
        instr(0, 0, 1);
      end
    end

    // R2: disabled source stays latched and is not taken
    en_i = '0;
    pulse_src(4);
    instr(0, 0, 0); instr(0, 0, 0);
    chk("R2 disabled source not taken", entering_o, 0);
    chk("R5 flag kept while disabled", flag_o[4], 1);
    en_i = N'(1) << 4;
    take_now(4, BASE_A);
    instr(0, 0, 1);

    // R10: CLI in the same cycle as a pending request
    en_i = '1;
    pulse_src(5);
    instr(0, 1, 0);
    chk("R10 cli blocks entry", entering_o, 0);
    chk("R10 cli clears gie", gie_o, 0);
    // R2: global enable off
    instr(0, 0, 0); instr(0, 0, 0);
    chk("R2 gie off blocks entry", entering_o, 0);
    instr(1, 0, 0);
    take_now(5, BASE_A);
    instr(0, 0, 1);

    // R11: multi-cycle instruction delays entry
    pulse_src(2);
    repeat (5) tick();
    chk("R11 waits for retire", entering_o, 0);
    take_now(2, BASE_A);
    instr(0, 0, 1);

    // R6: write-one-to-clear, and R5 set wins over clear
    en_i = '0;
    src_i[7] = 1; src_i[8] = 1; tick(); src_i = '0; tick();
    flag_clr_i = N'(1) << 7; tick(); flag_clr_i = '0;
    chk("R6 only bit 7 cleared", flag_o, N'(1) << 8);
    flag_clr_i = N'(1) << 8; tick(); flag_clr_i = '0;
    chk("R6 all cleared", flag_o, 0);
    src_i[3] = 1; flag_clr_i = N'(1) << 3; tick(); src_i = '0; flag_clr_i = '0;
    chk("R5 set wins over clear", flag_o[3], 1);
    flag_clr_i = N'(1) << 3; tick(); flag_clr_i = '0;
    en_i = '1;
    instr(0, 0, 0);
    chk("R6 cleared flag not taken", entering_o, 0);

    // R12: entry from sleep is longer
    sleep_i = 1;
    pulse_src(6);
    chk("R12 sleep entry started", entering_o, 1);
    sleep_i = 0;
    finish_entry(6, 8, BASE_A);
    instr(0, 0, 1);

    // R13: three flags pending when gie rises, served in order
    instr(0, 1, 0);
    src_i[9] = 1; src_i[3] = 1; src_i[5] = 1; tick(); src_i = '0; tick();
    instr(1, 0, 0);
    chk("R13 no entry on sei boundary", entering_o, 0);
    take_now(3, BASE_A);
    chk("R13 others pending", flag_o, (N'(1) << 5) | (N'(1) << 9));
    instr(0, 0, 1);
    take_now(5, BASE_A);
    instr(0, 0, 1);
    take_now(9, BASE_A);
    chk("R13 all served", flag_o, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule